// File: doc/BRIEF.md
# Eight-Entry Output FIFO Controller

This block sits between a sample-processing datapath and a host read port. It buffers up to eight processed words. The datapath pushes words in with a write strobe, and the host pulls them out with a read strobe. The controller owns the write and read pointers, the storage array with its slot decoder, the depth count, the empty and full flags, a registered read-valid strobe that goes with each returned word, and an interrupt that tells the host data is waiting.

A synchronous soft clear puts the controller into a known starting state without the chip-wide reset. It parks the write pointer at slot 0 and the read pointer at slot 7. The read pointer advances before each read, so the first read after a clear fetches slot 0, which is where the first write after the clear landed. The clear also sets the empty flag and drops the depth, full flag, read-valid strobe and interrupt. Words held in the array are abandoned, not erased.

Top module: `ofifo_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, with no strobes applied, the outputs are `empty`=1, `full`=0, `depth`=0, `irq`=0 and `rd_valid`=0.
- R2: A write is accepted when `wr_stb`=1, `full`=0 and `soft_clr`=0. It stores `wr_data` at the write pointer, and the write pointer then advances modulo 8. Accepted words come back out in the order they were written.
- R3: A read is accepted when `rd_stb`=1, `empty`=0 and `soft_clr`=0. The read pointer first advances modulo 8, and then the word at the new pointer is returned. In the cycle after the accepted read, `rd_valid` is 1 for exactly one cycle and `rd_data` holds that word.
- R4: `depth` rises by one after an accepted write with no accepted read. It falls by one after an accepted read with no accepted write. It stays the same when both are accepted in the same cycle.
- R5: `full` is 1 exactly when `depth` is 8. A write while `full`=1 is ignored and leaves depth and the stored words unchanged. A read in the same cycle is still accepted.
- R6: A read while `empty`=1 is ignored: `rd_valid` stays 0, `depth` stays 0, and the next word written is the next word read.
- R7: `empty` is 1 exactly when `depth` is 0.
- R8: `irq` goes to 1 after a write is accepted while the FIFO is empty. It stays 1 while the FIFO holds data and returns to 0 once the FIFO becomes empty.
- R9: When `soft_clr`=1, any strobes in the same cycle are ignored. After the edge, the write pointer is 0 and the read pointer is 7, so the first word written after the clear is the first word read. Also after the edge, `empty`=1 and `depth`, `full`, `rd_valid` and `irq` are all 0.
- R10: Order is kept across any number of pointer wraps, including when writes and reads are interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Synchronous soft clear of pointers, flags and strobes |
| wr_stb | input | 1 | Write strobe from the datapath |
| wr_data | input | DATA_W (16) | Word to store |
| rd_stb | input | 1 | Read strobe from the host |
| rd_data | output | DATA_W (16) | Word returned by the last accepted read |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` as new |
| depth | output | CNT_W (4) | Number of stored words, 0 to 8 |
| empty | output | 1 | FIFO holds no word |
| full | output | 1 | FIFO holds eight words |
| irq | output | 1 | Data-available interrupt |

## Verification
On every cycle, the assertions check that the flags agree with the depth count and that depth moves by one in the direction the accepted strobes imply. They also check that strobes arriving while full or empty do not corrupt state, that an accepted read is followed by `rd_valid`, that the interrupt follows the empty flag, and that a soft clear produces the defined flag state. Properties cannot see data ordering or the read pointer preload of 7, because the pointers are not ports. Only the bench's scoreboard shows these, by comparing every returned word against the order of writes across overflow, underflow, simultaneous traffic, wraps and a clear taken with the pointers mid-array.

// File: rtl/ofifo_pkg.sv
package ofifo_pkg;

    localparam int unsigned DATA_W     = 16;
    localparam int unsigned DEPTH      = 8;
    localparam int unsigned PTR_W      = $clog2(DEPTH);
    localparam int unsigned CNT_W      = PTR_W + 1;
    localparam int unsigned WR_PRELOAD = 0;
    localparam int unsigned RD_PRELOAD = DEPTH - 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Accepted transfers in the current cycle
    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
    } xfer_t;

    // DEPTH is a power of two, so plain increment wraps modulo DEPTH
    function automatic ptr_t ptr_inc(input ptr_t p);
        return p + 1'b1;
    endfunction

endpackage

// File: rtl/ofifo_ptr.sv
module ofifo_ptr
    import ofifo_pkg::*;
#(
    parameter ptr_t PRELOAD = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output ptr_t ptr,
    output ptr_t ptr_nxt
);

    ptr_t ptr_q;

    assign ptr_nxt = ptr_inc(ptr_q);
    assign ptr     = ptr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr_q <= PRELOAD;
        end else if (adv) begin
            ptr_q <= ptr_nxt;
        end
    end

endmodule

// File: rtl/ofifo_store.sv
module ofifo_store
    import ofifo_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  ptr_t  waddr,
    input  word_t wdata,
    input  ptr_t  raddr,
    output word_t rdata
);

    logic [DEPTH-1:0] wsel;
    word_t            mem [DEPTH];

    // One-hot slot decoder
    for (genvar i = 0; i < DEPTH; i++) begin : g_dec
        assign wsel[i] = we && (waddr == ptr_t'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wsel[i]) begin
                mem[i] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ofifo_flags.sv
module ofifo_flags
    import ofifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  xfer_t xfer,
    output cnt_t  depth,
    output logic  empty,
    output logic  full,
    output logic  irq
);

    cnt_t depth_q, depth_nxt;
    logic empty_q, full_q, irq_q;

    always_comb begin
        unique case ({xfer.wr_ok, xfer.rd_ok})
            2'b10:   depth_nxt = depth_q + 1'b1;
            2'b01:   depth_nxt = depth_q - 1'b1;
            default: depth_nxt = depth_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            depth_q <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            depth_q <= depth_nxt;
            empty_q <= (depth_nxt == '0);
            full_q  <= (depth_nxt == CNT_W'(DEPTH));
            if (xfer.wr_ok && empty_q) begin
                irq_q <= 1'b1;
            end else if (depth_nxt == '0) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign depth = depth_q;
    assign empty = empty_q;
    assign full  = full_q;
    assign irq   = irq_q;

endmodule

// File: rtl/ofifo_ctrl.sv
module ofifo_ctrl
    import ofifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  depth,
    output logic              empty,
    output logic              full,
    output logic              irq
);

    xfer_t xfer;
    ptr_t  wr_ptr, wr_ptr_nxt;
    ptr_t  rd_ptr, rd_ptr_nxt;
    word_t slot_word;
    word_t rd_data_q;
    logic  rd_valid_q;

    // Flags are registered, so acceptance depends only on current state
    assign xfer.wr_ok = wr_stb && !full  && !soft_clr;
    assign xfer.rd_ok = rd_stb && !empty && !soft_clr;

    ofifo_ptr #(.PRELOAD(ptr_t'(WR_PRELOAD))) u_wr_ptr (
        .clk     (clk),
        .rst     (rst),
        .clr     (soft_clr),
        .adv     (xfer.wr_ok),
        .ptr     (wr_ptr),
        .ptr_nxt (wr_ptr_nxt)
    );

    ofifo_ptr #(.PRELOAD(ptr_t'(RD_PRELOAD))) u_rd_ptr (
        .clk     (clk),
        .rst     (rst),
        .clr     (soft_clr),
        .adv     (xfer.rd_ok),
        .ptr     (rd_ptr),
        .ptr_nxt (rd_ptr_nxt)
    );

    // Read address is the advanced pointer: advance, then read
    ofifo_store u_store (
        .clk   (clk),
        .we    (xfer.wr_ok),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr_nxt),
        .rdata (slot_word)
    );

    ofifo_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .clr   (soft_clr),
        .xfer  (xfer),
        .depth (depth),
        .empty (empty),
        .full  (full),
        .irq   (irq)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= xfer.rd_ok;
            if (xfer.rd_ok) begin
                rd_data_q <= slot_word;
            end
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

endmodule

// File: rtl/ofifo_ctrl_chk.sv
module ofifo_ctrl_chk
    import ofifo_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              soft_clr,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic              rd_valid,
    input logic [CNT_W-1:0]  depth,
    input logic              empty,
    input logic              full,
    input logic              irq
);

    assert_empty_flag_R7: assert property (@(posedge clk) disable iff (rst)
        empty == (depth == '0));

    assert_full_flag_R5: assert property (@(posedge clk) disable iff (rst)
        full == (depth == CNT_W'(DEPTH)));

    assert_depth_up_R4: assert property (@(posedge clk) disable iff (rst)
        (!soft_clr && wr_stb && !full && !(rd_stb && !empty))
        |=> depth == CNT_W'($past(depth) + 1'b1));

    assert_depth_down_R4: assert property (@(posedge clk) disable iff (rst)
        (!soft_clr && rd_stb && !empty && !(wr_stb && !full))
        |=> depth == CNT_W'($past(depth) - 1'b1));

    assert_depth_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!soft_clr && wr_stb && !full && rd_stb && !empty) |=> $stable(depth));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (!soft_clr && full && wr_stb && !rd_stb) |=> full);

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (!soft_clr && empty && rd_stb) |=> !rd_valid);

    assert_rd_valid_R3: assert property (@(posedge clk) disable iff (rst)
        (!soft_clr && rd_stb && !empty) |=> rd_valid);

    assert_irq_set_R8: assert property (@(posedge clk) disable iff (rst)
        (!soft_clr && empty && wr_stb) |=> irq);

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
        empty |-> !irq);

    assert_soft_clr_R9: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (empty && !full && depth == '0 && !irq && !rd_valid));

endmodule

bind ofifo_ctrl ofifo_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .soft_clr (soft_clr),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .rd_valid (rd_valid),
    .depth    (depth),
    .empty    (empty),
    .full     (full),
    .irq      (irq)
);

// File: tb/ofifo_ctrl_bench.sv
`timescale 1ns/1ps
module ofifo_ctrl_bench;
    import ofifo_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              soft_clr = 1'b0;
    logic              wr_stb = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_stb = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic [CNT_W-1:0]  depth;
    logic              empty, full, irq;

    always #2.5 clk = ~clk;

    ofifo_ctrl u_ofifo_ctrl (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .wr_stb(wr_stb),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
        .rd_valid(rd_valid), .depth(depth), .empty(empty), .full(full),
        .irq(irq)
    );

    int    checks = 0;
    int    errors = 0;
    word_t sb_q[$];
    int    m_depth = 0;
    bit    m_irq = 1'b0;
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, model update, flag checks after the edge
    task automatic step(input bit w, input word_t d, input bit r, input bit s);
        bit wa, ra;
        @(negedge clk);
        wr_stb = w; wr_data = d; rd_stb = r; soft_clr = s;
        wa = w && !s && (m_depth < DEPTH);
        ra = r && !s && (m_depth > 0);
        @(posedge clk);
        if (s) begin
            sb_q.delete();
            m_depth = 0;
            m_irq = 1'b0;
        end else begin
            if (wa) sb_q.push_back(d);
            if (wa && !ra) begin
                if (m_depth == 0) m_irq = 1'b1;
                m_depth++;
            end else if (ra && !wa) begin
                m_depth--;
            end
            if (m_depth == 0) m_irq = 1'b0;
        end
        #1;
        chk(depth == m_depth, "R4", "depth", depth, m_depth);
        chk(empty == (m_depth == 0), "R7", "empty", empty, m_depth == 0);
        chk(full == (m_depth == DEPTH), "R5", "full", full, m_depth == DEPTH);
        chk(irq == m_irq, "R8", "irq", irq, m_irq);
        chk(rd_valid == ra, "R3 R6", "rd_valid", rd_valid, ra);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0);
    endtask

    // Monitor: every returned word must be the oldest pending one
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2", "read with nothing pending", 1, 0);
            end else begin
                word_t exp_w;
                exp_w = sb_q.pop_front();
                chk(rd_data == exp_w, "R2 R10", "rd_data", rd_data, exp_w);
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: state during reset
        #1;
        chk(empty == 1'b1, "R1", "empty in reset", empty, 1);
        chk(irq == 1'b0, "R1", "irq in reset", irq, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(empty == 1'b1, "R1", "empty", empty, 1);
        chk(full == 1'b0, "R1", "full", full, 0);
        chk(depth == 0, "R1", "depth", depth, 0);
        chk(irq == 1'b0, "R1", "irq", irq, 0);
        chk(rd_valid == 1'b0, "R1", "rd_valid", rd_valid, 0);

        // R2 R3: first word after reset lands in slot 0 and reads back
        step(1'b1, 16'hA001, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        idle(1);

        // R6: read while empty is ignored, next word is the next read
        step(1'b0, '0, 1'b1, 1'b0);
        chk(rd_valid == 1'b0, "R6", "rd_valid on empty read", rd_valid, 0);
        step(1'b1, 16'hB002, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        idle(1);

        // R5: fill, overflow write ignored, drain, underflow read ignored
        for (int i = 0; i < DEPTH; i++) step(1'b1, word_t'(16'hC000 + i), 1'b0, 1'b0);
        chk(full == 1'b1, "R5", "full after 8 writes", full, 1);
        step(1'b1, 16'hDEAD, 1'b0, 1'b0);
        chk(depth == DEPTH, "R5", "depth after overflow write", depth, DEPTH);
        // R5: full with both strobes -> read wins, write dropped
        step(1'b1, 16'hBEEF, 1'b1, 1'b0);
        for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1, 1'b0);
        chk(empty == 1'b1, "R6", "empty after drain", empty, 1);
        idle(1);

        // R4: simultaneous read and write keep depth
        for (int i = 0; i < 3; i++) step(1'b1, word_t'(16'hD000 + i), 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, word_t'(16'hD100 + i), 1'b1, 1'b0);
        chk(depth == 3, "R4", "depth after mixed traffic", depth, 3);
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, 1'b0);
        idle(1);

        // R10: many wraps with interleaved traffic
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 3; i++) step(1'b1, word_t'(16'hE000 + k * 16 + i), 1'b0, 1'b0);
            for (int i = 0; i < 2; i++) step(1'b0, '0, 1'b1, 1'b0);
        end
        for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1, 1'b0);
        idle(1);
        chk(sb_q.size() == 0, "R10", "pending after wraps", sb_q.size(), 0);

        // R9: soft clear with pointers mid-array and strobes active
        for (int i = 0; i < 5; i++) step(1'b1, word_t'(16'hF000 + i), 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b1, 16'h1234, 1'b1, 1'b1);
        chk(empty == 1'b1 && depth == 0, "R9", "empty/depth after clear", depth, 0);
        chk(rd_valid == 1'b0 && irq == 1'b0, "R9", "rd_valid/irq after clear", rd_valid + irq, 0);
        step(1'b0, '0, 1'b0, 1'b0);
        step(1'b1, 16'h5A5A, 1'b0, 1'b0);
        step(1'b1, 16'h6B6B, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0);
        idle(2);
        chk(sb_q.size() == 0, "R9", "pending after clear sequence", sb_q.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule